// File: doc/BRIEF.md
# Interrupting Multi-Counter Event Monitor

This block watches a vector of single-cycle event strobes and counts them in eight 32-bit counters. Each counter has its own byte-wide selector that names which event strobe it follows. The value 0, and any value past the last event input, leave the counter idle. One shared control word holds three things: a global run bit, one interrupt-enable bit per counter, and one sticky overflow flag per counter. Software clears a flag by writing a one to it.

Software sets a sampling period by writing the two's-complement negative of the period into a counter. The counter then wraps from all-ones to zero after exactly that many selected events. The wrap sets the counter's flag. While the matching enable bit is set, the flag drives that counter's own interrupt line. The interrupt handler reloads the counter and writes one to the flag to clear it. It can also drop a single interrupt enable while every other counter keeps running.

Access goes through a single-cycle register port. A write takes effect at the next clock edge. A read returns data combinationally for the address presented.

Top module: `evmon_top`

## Requirements
- R1: After reset every counter, every selector, the run bit, all interrupt enables and all overflow flags read as zero, and no interrupt line is high.
- R2: In each clock in which the run bit is set and the event input chosen by a counter's selector is high, that counter goes up by exactly one. Selector value v from 1 to 16 picks event input bit v-1. Selector values 0 and 17 to 255 count nothing.
- R3: A write to selector n (address 16+n) keeps only bits 7:0 of the write data. A read of the selector returns those 8 bits zero-extended.
- R4: Counter n can be written directly at address 8+n. When a write and a counted event fall in the same clock, the written value is stored and the event is lost.
- R5: Control bit 0 is the run bit. While it is clear, no counter changes except by a direct write.
- R6: When counter n steps from 0xFFFFFFFF to 0, control bit 16+n (the overflow flag) is set and stays set until it is cleared.
- R7: Writing 1 to control bit 16+n clears flag n. Writing 0 to it leaves the flag unchanged. An overflow in the same clock as the clear leaves the flag set.
- R8: Interrupt line n is high exactly when flag n and control bit 8+n (the interrupt enable) are both set. Clearing an enable does not stop any counter.
- R9: A read of address 0 returns the control word: the run bit in bit 0, the enables in bits 15:8 and the live flags in bits 23:16, with all other bits zero. Addresses 8+n return counter n. All unmapped addresses read zero.
- R10: The run bit and the enable bits are plain read/write bits. Control write bits 7:1 and 31:24 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| evt_i | input | 16 | Event strobes, one bit per event source |
| irq_o | output | 8 | One interrupt line per counter |

## Verification
The bench goes after three collisions. The first is a direct counter write in the same clock as a selected event; a design that let the event win would read one above the written value. The second is a write-one-to-clear that lands on the clock of a wrap; a design that gave the clear priority would lose that overflow and never raise the interrupt. The third is writing zeros into the flag field while rewriting the enables, which a design that treated flags as plain bits would wrongly clear. It also checks selectors loaded with 0 or with values above the event count, and a write wider than a byte, where a design that decoded extra bits or ignored the range check would count stray events. It checks dropping one interrupt enable, where the flag must stay visible and other counters must keep going.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  // Control word layout: fixed offsets that software relies on
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IE_LSB  = 8;
  localparam int unsigned CTRL_OVF_LSB = 16;

  // Register map (word addresses)
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_CNT_BASE = 8;
  localparam int unsigned ADDR_SEL_BASE = 16;

  // A selector picks event bit (sel-1); 0 and anything past the last input is idle
  function automatic logic sel_is_live(int unsigned sel, int unsigned num_evt);
    return (sel != 0) && (sel <= num_evt);
  endfunction

  // Assemble the readable control word from its three fields
  function automatic logic [31:0] pack_ctrl(logic run, logic [7:0] ie, logic [7:0] ovf);
    logic [31:0] w;
    w = '0;
    w[CTRL_RUN_BIT] = run;
    w[CTRL_IE_LSB +: 8] = ie;
    w[CTRL_OVF_LSB +: 8] = ovf;
    return w;
  endfunction

endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEL_W = 8,
  parameter int unsigned EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_we,
  input  logic             sel_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [EVT_W-1:0] evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             wrap
);
  import evmon_pkg::*;

  logic picked;
  logic hit;
  logic step;

  // Event pick by comparison, so no index can run out of range
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < int'(EVT_W); i++) begin
      if (sel_q == SEL_W'(i + 1)) picked = evt[i];
    end
  end

  assign hit  = run && sel_is_live(32'(sel_q), EVT_W) && picked;
  assign step = hit && !cnt_we;            // a direct write beats an event
  assign wrap = step && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (cnt_we)     cnt_q <= wdata;
      else if (step)  cnt_q <= cnt_q + 1'b1;
      if (sel_we)     sel_q <= wdata[SEL_W-1:0];
    end
  end

  AST_IDLE_SELECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 && !cnt_we) |=> $stable(cnt_q)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata))); // R4
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q)); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl #(
  parameter int unsigned NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               run_wdata,
  input  logic [NUM_CTR-1:0] ie_wdata,
  input  logic [NUM_CTR-1:0] clr_wdata,
  input  logic [NUM_CTR-1:0] wrap_vec,
  output logic               run_q,
  output logic [NUM_CTR-1:0] ie_q,
  output logic [NUM_CTR-1:0] ovf_q,
  output logic [NUM_CTR-1:0] irq
);

  logic [NUM_CTR-1:0] clr_mask;
  logic [NUM_CTR-1:0] ovf_d;

  assign clr_mask = ctrl_we ? clr_wdata : '0;
  assign ovf_d    = (ovf_q & ~clr_mask) | wrap_vec;   // a set beats a clear
  assign irq      = ovf_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ie_q  <= '0;
      ovf_q <= '0;
    end else begin
      ovf_q <= ovf_d;
      if (ctrl_we) begin
        run_q <= run_wdata;
        ie_q  <= ie_wdata;
      end
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & $past(ovf_q & ~clr_mask)) == $past(ovf_q & ~clr_mask))); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & $past(clr_mask & ~wrap_vec)) == '0)); // R7
  AST_ENABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ($stable(ie_q) && $stable(run_q))); // R10

endmodule

// File: rtl/evmon_rdmux.sv
module evmon_rdmux #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   ctrl_word,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NUM_CTR-1:0][SEL_W-1:0] sel_vec,
  output logic [31:0]                   rdata
);
  import evmon_pkg::*;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) rdata = ctrl_word;
    for (int n = 0; n < int'(NUM_CTR); n++) begin
      if (addr == ADDR_W'(ADDR_CNT_BASE + n)) rdata = 32'(cnt_vec[n]);
      if (addr == ADDR_W'(ADDR_SEL_BASE + n)) rdata = 32'(sel_vec[n]);
    end
  end

endmodule

// File: rtl/evmon_top.sv
module evmon_top #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned EVT_W   = 16,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [NUM_CTR-1:0] irq_o
);
  import evmon_pkg::*;

  logic                        ctrl_we;
  logic                        run_q;
  logic [NUM_CTR-1:0]          ie_q;
  logic [NUM_CTR-1:0]          ovf_q;
  logic [NUM_CTR-1:0]          wrap_vec;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel_vec;
  logic [31:0]                 ctrl_word;

  assign ctrl_we = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic cnt_we_n;
    logic sel_we_n;
    assign cnt_we_n = reg_we && (reg_addr == ADDR_W'(ADDR_CNT_BASE + n));
    assign sel_we_n = reg_we && (reg_addr == ADDR_W'(ADDR_SEL_BASE + n));

    evmon_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .EVT_W(EVT_W)) i_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .cnt_we (cnt_we_n),
      .sel_we (sel_we_n),
      .wdata  (reg_wdata[CNT_W-1:0]),
      .evt    (evt_i),
      .cnt_q  (cnt_vec[n]),
      .sel_q  (sel_vec[n]),
      .wrap   (wrap_vec[n])
    );
  end

  evmon_ctrl #(.NUM_CTR(NUM_CTR)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .run_wdata (reg_wdata[CTRL_RUN_BIT]),
    .ie_wdata  (reg_wdata[CTRL_IE_LSB +: NUM_CTR]),
    .clr_wdata (reg_wdata[CTRL_OVF_LSB +: NUM_CTR]),
    .wrap_vec  (wrap_vec),
    .run_q     (run_q),
    .ie_q      (ie_q),
    .ovf_q     (ovf_q),
    .irq       (irq_o)
  );

  assign ctrl_word = pack_ctrl(run_q, 8'(ie_q), 8'(ovf_q));

  evmon_rdmux #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) i_rdmux (
    .addr      (reg_addr),
    .ctrl_word (ctrl_word),
    .cnt_vec   (cnt_vec),
    .sel_vec   (sel_vec),
    .rdata     (reg_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0)); // R1
  AST_IRQ_DROPS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !reg_wdata[CTRL_IE_LSB]) |=> !irq_o[0]); // R8

endmodule

// File: tb/test_evmon_top.sv
`timescale 1ns/1ps
module test_evmon_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] evt_i = '0;
  logic [7:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evmon_top i_evmon_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [31:0] m_cnt [8];
  logic [7:0]  m_sel [8];
  logic        m_run;
  logic [7:0]  m_ie;
  logic [7:0]  m_ovf;

  function automatic logic [31:0] m_read(logic [4:0] a);
    if (a == 0) return {8'h00, m_ovf, m_ie, 7'b0, m_run};
    if (a >= 8 && a < 16) return m_cnt[a - 8];
    if (a >= 16 && a < 24) return {24'h0, m_sel[a - 16]};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
      m_run = 1'b0; m_ie = '0; m_ovf = '0;
    end else begin
      logic [7:0] wraps;
      logic [7:0] clr;
      wraps = '0;
      for (int n = 0; n < 8; n++) begin
        int s;
        bit counted;
        s = m_sel[n];
        counted = m_run && s >= 1 && s <= 16 && evt_i[s - 1];
        if (reg_we && reg_addr == 5'(8 + n)) m_cnt[n] = reg_wdata;
        else if (counted) begin
          if (m_cnt[n] == 32'hFFFF_FFFF) wraps[n] = 1'b1;
          m_cnt[n] = m_cnt[n] + 1;
        end
        if (reg_we && reg_addr == 5'(16 + n)) m_sel[n] = reg_wdata[7:0];
      end
      clr = (reg_we && reg_addr == 0) ? reg_wdata[23:16] : 8'h00;
      m_ovf = (m_ovf & ~clr) | wraps;
      if (reg_we && reg_addr == 0) begin
        m_run = reg_wdata[0];
        m_ie  = reg_wdata[15:8];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R8 irq vs model", {24'h0, irq_o}, {24'h0, m_ovf & m_ie});
      check("R9 rdata vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic pulse(logic [15:0] e, int cycles);
    @(negedge clk);
    evt_i = e;
    repeat (cycles - 1) @(negedge clk);
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int n = 0; n < 8; n++) begin
      rd(5'(8 + n), 32'h0, "R1 counter reset");
      rd(5'(16 + n), 32'h0, "R1 selector reset");
    end
    rd(5'd0, 32'h0, "R1 control reset");
    check("R1 irq reset", {24'h0, irq_o}, 32'h0);

    // R3: only low byte of selector is kept
    wr(5'd16, 32'h0000_0001);
    wr(5'd17, 32'h0000_0302);
    rd(5'd17, 32'h0000_0002, "R3 selector low byte");
    wr(5'd0, 32'h0000_0701);
    rd(5'd0, 32'h0000_0701, "R10 run and enables readback");

    // R2: counting under different patterns
    @(negedge clk); evt_i = 16'h0003;
    repeat (3) @(negedge clk);
    evt_i = 16'h0001;
    repeat (2) @(negedge clk);
    evt_i = 16'h0000;
    rd(5'd8, 32'd5, "R2 counter0 counts event0");
    rd(5'd9, 32'd3, "R2 counter1 counts event1");
    rd(5'd10, 32'd0, "R2 selector zero idle");

    // R5: run bit off stops counting
    wr(5'd0, 32'h0000_0700);
    pulse(16'hFFFF, 4);
    rd(5'd8, 32'd5, "R5 stopped counter holds");

    // R6: overflow after preloaded period
    wr(5'd8, 32'hFFFF_FFFD);
    wr(5'd0, 32'h0000_0701);
    pulse(16'h0001, 3);
    rd(5'd8, 32'd0, "R6 wrap to zero");
    rd(5'd0, 32'h0001_0701, "R6 flag set on wrap");
    check("R8 irq0 raised", {24'h0, irq_o}, 32'h1);
    pulse(16'h0001, 2);
    rd(5'd0, 32'h0001_0701, "R6 flag sticky");

    // R7: write zero keeps, write one clears
    wr(5'd0, 32'h0000_0701);
    rd(5'd0, 32'h0001_0701, "R7 zero write keeps flag");
    wr(5'd0, 32'h0001_0701);
    rd(5'd0, 32'h0000_0701, "R7 one write clears flag");
    check("R8 irq0 dropped", {24'h0, irq_o}, 32'h0);

    // R7: overflow in the clear cycle wins
    wr(5'd9, 32'hFFFF_FFFF);
    @(negedge clk);
    evt_i = 16'h0002; reg_we = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h0002_0701;
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0;
    rd(5'd9, 32'd0, "R7 counter1 wrapped");
    rd(5'd0, 32'h0002_0701, "R7 set beats clear");

    // R4: direct write beats same-cycle event
    @(negedge clk);
    evt_i = 16'h0001; reg_we = 1'b1; reg_addr = 5'd8; reg_wdata = 32'd100;
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0;
    rd(5'd8, 32'd100, "R4 write wins over event");

    // R8: dropping one enable leaves counting running
    check("R8 irq1 raised", {24'h0, irq_o}, 32'h2);
    wr(5'd0, 32'h0000_0501);
    check("R8 irq1 masked", {24'h0, irq_o}, 32'h0);
    rd(5'd0, 32'h0002_0501, "R8 flag still visible");
    pulse(16'h0001, 3);
    rd(5'd8, 32'd103, "R8 other counters keep running");

    // R10: ignored control bits
    wr(5'd0, 32'hFE00_00FE);
    rd(5'd0, 32'h0002_0000, "R10 ignored bits");

    // R9: unmapped address
    rd(5'd5, 32'h0, "R9 unmapped reads zero");
    rd(5'd30, 32'h0, "R9 high unmapped reads zero");

    // R2/R3: out-of-range selector counts nothing
    wr(5'd19, 32'h0000_01FF);
    rd(5'd19, 32'h0000_00FF, "R3 wide write truncated");
    wr(5'd0, 32'h0000_0001);
    pulse(16'hFFFF, 4);
    rd(5'd11, 32'd0, "R2 out-of-range selector idle");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule